// File: doc/BRIEF.md
# Two-Stage Translation Mode Selector

This block sits beside a first-level address-translation cache in a core that supports hypervisor-style nested translation. For every lookup request it works out which translation stages apply. The choice comes from the virtualization state and from the mode fields of the guest and host translation-control registers. There are four possible modes: no second stage, guest stage alone, host stage alone, or both stages nested. At request time it also runs the address-range checks that do not need a lookup. One cycle later it combines the stage lookup results into a single response: a 36-bit physical page number, the guest physical address, and the fault flags that apply to that mode.

A request enters stage 0 through a valid/ready handshake, and the block registers the decoded mode and the range-check flags along with the virtual address. In stage 1 the translation storage drives both lookup results, and the block presents the response through a second valid/ready handshake. Back-pressure works as follows. While `rsp_valid` is high and `rsp_ready` is low, the stage-1 entry holds, `req_ready` stays low, and every registered response field stays stable. The lookup inputs must keep matching the held entry for as long as it waits. A new request can be accepted in the same cycle that the held response is consumed.

Top module: `xlate_mode_sel`

## Requirements
- R1: When `req_virt` is 0 at acceptance, the response mode is 2'b00 (no second stage), whatever the two mode fields hold.
- R2: When `req_virt` is 1 at acceptance, the response mode is 2'b11 if both fields are nonzero, 2'b01 if only the guest field is nonzero, 2'b10 if only the host field is nonzero, and 2'b00 if both are zero.
- R3: `rsp_ppn` is bits [35:0] of `lk_s1_ppn` in modes 2'b00 and 2'b01, and bits [35:0] of `lk_s2_ppn` in modes 2'b10 and 2'b11.
- R4: `rsp_gpa` is the captured virtual address bits [49:0] in mode 2'b10. It is {`lk_s1_ppn`[37:0], vaddr[11:0]} in modes 2'b01 and 2'b11, and zero in mode 2'b00.
- R5: `rsp_af` equals `lk_s1_af` in modes 2'b00 and 2'b01, so a host-stage fault is ignored in guest-only mode. It equals `lk_s2_af` in mode 2'b10, and the OR of both in mode 2'b11.
- R6: `rsp_pf` is set only in modes 2'b01 and 2'b11, and only when vaddr bits [63:47] are not all equal. `rsp_gpf` is set only in mode 2'b10, and only when vaddr bits [63:50] are not all zero.
- R7: The mode, the range-check flags and the address used in a response are those present at acceptance. Changing `req_virt`, the mode fields or `req_vaddr` after acceptance has no effect on that response.
- R8: An accepted request gives `rsp_valid` on the next cycle. While `rsp_ready` is low the response and its fields hold and `req_ready` is low. `req_ready` is high whenever no response is pending or `rsp_ready` is high.
- R9: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present in stage 0 |
| req_ready | output | 1 | Stage 0 can accept |
| req_vaddr | input | 64 | Virtual address of the request |
| req_virt | input | 1 | Virtualization active for this request |
| req_guest_fld | input | 4 | Guest translation-control mode field |
| req_host_fld | input | 4 | Host translation-control mode field |
| lk_s1_ppn | input | 44 | First-stage lookup page number (stage 1) |
| lk_s1_af | input | 1 | First-stage access fault (stage 1) |
| lk_s2_ppn | input | 38 | Second-stage lookup page number (stage 1) |
| lk_s2_af | input | 1 | Second-stage access fault (stage 1) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_mode | output | 2 | Translation mode of the response |
| rsp_ppn | output | 36 | Selected physical page number |
| rsp_gpa | output | 50 | Guest physical address |
| rsp_af | output | 1 | Access fault that applies to the mode |
| rsp_pf | output | 1 | Pre-translation page fault (guest stage range) |
| rsp_gpf | output | 1 | Pre-translation guest-page fault (host stage range) |

## Verification
The assertions run every cycle. They check that a held response keeps its mode and flags while stalled, and that acceptance always leads to a response. They check that an accepted request with virtualization off or with both fields set yields the expected mode, and that no range flag or host-stage fault shows up in a mode where it cannot apply. The bench's sweep is needed for the rest. It covers every pairing of the virtualization bit, zero and nonzero fields, four address shapes and all fault combinations. It also scrambles the inputs after acceptance, and only that can show that the values captured in stage 0 decide the result. The sweep also checks the exact page-number and guest-address bits.

// File: rtl/xlate_sel_pkg.sv
package xlate_sel_pkg;

  typedef enum logic [1:0] {
    XM_BARE   = 2'b00,
    XM_GUEST  = 2'b01,
    XM_HOST   = 2'b10,
    XM_NESTED = 2'b11
  } xmode_e;

  function automatic logic uses_guest(input xmode_e m);
    return m[0];
  endfunction

  function automatic logic uses_host(input xmode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/xlate_mode_decode.sv
module xlate_mode_decode
  import xlate_sel_pkg::*;
#(
  parameter int GFLD_W = 4,
  parameter int HFLD_W = 4
) (
  input  logic              virt_on,
  input  logic [GFLD_W-1:0] guest_fld,
  input  logic [HFLD_W-1:0] host_fld,
  output xmode_e            mode
);

  logic guest_on;
  logic host_on;

  assign guest_on = |guest_fld;
  assign host_on  = |host_fld;

  always_comb begin
    if (!virt_on) begin
      mode = XM_BARE;
    end else begin
      unique case ({host_on, guest_on})
        2'b11:   mode = XM_NESTED;
        2'b01:   mode = XM_GUEST;
        2'b10:   mode = XM_HOST;
        default: mode = XM_BARE;
      endcase
    end
  end

endmodule

// File: rtl/xlate_pre_check.sv
module xlate_pre_check
  import xlate_sel_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int SIG_W = 48,
  parameter int GPA_W = 50
) (
  input  xmode_e          mode,
  input  logic [VA_W-1:0] vaddr,
  output logic            pre_pf,
  output logic            pre_gpf
);

  localparam int EXT_W = VA_W - SIG_W + 1;

  logic sig_bad;
  logic gpa_bad;

  generate
    if (SIG_W < VA_W) begin : g_sig
      logic [EXT_W-1:0] ext_bits;
      assign ext_bits = vaddr[VA_W-1:SIG_W-1];
      assign sig_bad  = !((ext_bits == '0) || (ext_bits == '1));
    end else begin : g_nosig
      assign sig_bad = 1'b0;
    end

    if (GPA_W < VA_W) begin : g_gpa
      assign gpa_bad = |vaddr[VA_W-1:GPA_W];
    end else begin : g_nogpa
      assign gpa_bad = 1'b0;
    end
  endgenerate

  assign pre_pf  = uses_guest(mode) && sig_bad;
  assign pre_gpf = (mode == XM_HOST) && gpa_bad;

endmodule

// File: rtl/xlate_result_mux.sv
module xlate_result_mux
  import xlate_sel_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int OFF_W     = 12,
  parameter int PPN1_W    = 44,
  parameter int PPN2_W    = 38,
  parameter int PPN_OUT_W = 36,
  parameter int GPA_W     = 50
) (
  input  xmode_e               mode,
  input  logic [VA_W-1:0]      vaddr,
  input  logic [PPN1_W-1:0]    s1_ppn,
  input  logic                 s1_af,
  input  logic [PPN2_W-1:0]    s2_ppn,
  input  logic                 s2_af,
  output logic [PPN_OUT_W-1:0] ppn,
  output logic [GPA_W-1:0]     gpa,
  output logic                 af
);

  localparam int GPN_W = GPA_W - OFF_W;

  logic [PPN_OUT_W-1:0] s1_fit;
  logic [PPN_OUT_W-1:0] s2_fit;
  logic [GPN_W-1:0]     s1_gpn;
  logic [GPA_W-1:0]     va_gpa;
  logic                 unused_hi_bits;

  generate
    if (PPN1_W >= PPN_OUT_W) begin : g_s1_cut
      assign s1_fit = s1_ppn[PPN_OUT_W-1:0];
    end else begin : g_s1_ext
      assign s1_fit = PPN_OUT_W'(s1_ppn);
    end

    if (PPN2_W >= PPN_OUT_W) begin : g_s2_cut
      assign s2_fit = s2_ppn[PPN_OUT_W-1:0];
    end else begin : g_s2_ext
      assign s2_fit = PPN_OUT_W'(s2_ppn);
    end

    if (PPN1_W >= GPN_W) begin : g_gpn_cut
      assign s1_gpn = s1_ppn[GPN_W-1:0];
    end else begin : g_gpn_ext
      assign s1_gpn = GPN_W'(s1_ppn);
    end

    if (VA_W >= GPA_W) begin : g_va_cut
      assign va_gpa = vaddr[GPA_W-1:0];
    end else begin : g_va_ext
      assign va_gpa = GPA_W'(vaddr);
    end
  endgenerate

  assign unused_hi_bits = ^{s1_ppn, s2_ppn, vaddr};

  always_comb begin
    ppn = uses_host(mode) ? s2_fit : s1_fit;
    unique case (mode)
      XM_HOST:   gpa = va_gpa;
      XM_GUEST,
      XM_NESTED: gpa = {s1_gpn, vaddr[OFF_W-1:0]};
      default:   gpa = '0;
    endcase
    unique case (mode)
      XM_HOST:   af = s2_af;
      XM_NESTED: af = s1_af | s2_af;
      default:   af = s1_af;
    endcase
  end

endmodule

// File: rtl/xlate_mode_sel.sv
module xlate_mode_sel
  import xlate_sel_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int SIG_W     = 48,
  parameter int GPA_W     = 50,
  parameter int OFF_W     = 12,
  parameter int PPN1_W    = 44,
  parameter int PPN2_W    = 38,
  parameter int PPN_OUT_W = 36,
  parameter int GFLD_W    = 4,
  parameter int HFLD_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic                 req_virt,
  input  logic [GFLD_W-1:0]    req_guest_fld,
  input  logic [HFLD_W-1:0]    req_host_fld,
  input  logic [PPN1_W-1:0]    lk_s1_ppn,
  input  logic                 lk_s1_af,
  input  logic [PPN2_W-1:0]    lk_s2_ppn,
  input  logic                 lk_s2_af,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_mode,
  output logic [PPN_OUT_W-1:0] rsp_ppn,
  output logic [GPA_W-1:0]     rsp_gpa,
  output logic                 rsp_af,
  output logic                 rsp_pf,
  output logic                 rsp_gpf
);

  xmode_e          st0_mode;
  logic            st0_pf;
  logic            st0_gpf;
  logic            st0_fire;

  logic            st1_vld;
  xmode_e          st1_mode;
  logic [VA_W-1:0] st1_vaddr;
  logic            st1_pf;
  logic            st1_gpf;

  xlate_mode_decode #(
    .GFLD_W (GFLD_W),
    .HFLD_W (HFLD_W)
  ) u_decode (
    .virt_on   (req_virt),
    .guest_fld (req_guest_fld),
    .host_fld  (req_host_fld),
    .mode      (st0_mode)
  );

  xlate_pre_check #(
    .VA_W  (VA_W),
    .SIG_W (SIG_W),
    .GPA_W (GPA_W)
  ) u_precheck (
    .mode    (st0_mode),
    .vaddr   (req_vaddr),
    .pre_pf  (st0_pf),
    .pre_gpf (st0_gpf)
  );

  assign req_ready = !st1_vld || rsp_ready;
  assign st0_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_vld   <= 1'b0;
      st1_mode  <= XM_BARE;
      st1_vaddr <= '0;
      st1_pf    <= 1'b0;
      st1_gpf   <= 1'b0;
    end else if (req_ready) begin
      st1_vld <= req_valid;
      if (req_valid) begin
        st1_mode  <= st0_mode;
        st1_vaddr <= req_vaddr;
        st1_pf    <= st0_pf;
        st1_gpf   <= st0_gpf;
      end
    end
  end

  xlate_result_mux #(
    .VA_W      (VA_W),
    .OFF_W     (OFF_W),
    .PPN1_W    (PPN1_W),
    .PPN2_W    (PPN2_W),
    .PPN_OUT_W (PPN_OUT_W),
    .GPA_W     (GPA_W)
  ) u_mux (
    .mode   (st1_mode),
    .vaddr  (st1_vaddr),
    .s1_ppn (lk_s1_ppn),
    .s1_af  (lk_s1_af),
    .s2_ppn (lk_s2_ppn),
    .s2_af  (lk_s2_af),
    .ppn    (rsp_ppn),
    .gpa    (rsp_gpa),
    .af     (rsp_af)
  );

  assign rsp_valid = st1_vld;
  assign rsp_mode  = st1_mode;
  assign rsp_pf    = st1_pf;
  assign rsp_gpf   = st1_gpf;

  // R1
  bare_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_fire && !req_virt) |=> (rsp_mode == 2'b00));

  // R2
  nested_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_fire && req_virt && (|req_guest_fld) && (|req_host_fld)) |=> (rsp_mode == 2'b11));

  // R5
  guest_only_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mode == 2'b01 && !lk_s1_af) |-> !rsp_af);

  // R6
  bare_no_prefault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mode == 2'b00) |-> (!rsp_pf && !rsp_gpf));

  // R8
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st0_fire |=> rsp_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mode) && $stable(rsp_pf) && $stable(rsp_gpf)));

endmodule

// File: tb/xlate_mode_sel_bench.sv
module xlate_mode_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        req_virt = 1'b0;
  logic [3:0]  req_guest_fld = '0;
  logic [3:0]  req_host_fld = '0;
  logic [43:0] lk_s1_ppn = '0;
  logic        lk_s1_af = 1'b0;
  logic [37:0] lk_s2_ppn = '0;
  logic        lk_s2_af = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_mode;
  logic [35:0] rsp_ppn;
  logic [49:0] rsp_gpa;
  logic        rsp_af;
  logic        rsp_pf;
  logic        rsp_gpf;

  int errs = 0;
  int total = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  xlate_mode_sel u_xlate_mode_sel (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_virt(req_virt), .req_guest_fld(req_guest_fld), .req_host_fld(req_host_fld),
    .lk_s1_ppn(lk_s1_ppn), .lk_s1_af(lk_s1_af), .lk_s2_ppn(lk_s2_ppn), .lk_s2_af(lk_s2_af),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_mode(rsp_mode), .rsp_ppn(rsp_ppn),
    .rsp_gpa(rsp_gpa), .rsp_af(rsp_af), .rsp_pf(rsp_pf), .rsp_gpf(rsp_gpf)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fld_val(input int idx);
    case (idx)
      0: return 4'h0;
      1: return 4'h1;
      2: return 4'h8;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [63:0] va_val(input int idx);
    case (idx)
      0: return 64'h0000_0000_1234_5ABC;
      1: return 64'hFFFF_8000_0000_1ABC;
      2: return 64'h0001_0000_0000_0DEF;
      default: return 64'h0010_0000_0000_0777;
    endcase
  endfunction

  task automatic one_req(input logic virt, input logic [3:0] g, input logic [3:0] h,
                         input logic [63:0] va, input logic [43:0] p1, input logic [37:0] p2,
                         input logic a1, input logic a2);
    logic [1:0]  em;
    logic        epf;
    logic        egpf;
    logic [35:0] eppn;
    logic [49:0] egpa;
    logic        eaf;
    em   = virt ? {(h != 0), (g != 0)} : 2'b00;
    epf  = em[0] && !((va[63:47] == '0) || (va[63:47] == '1));
    egpf = (em == 2'b10) && (va[63:50] != '0);
    eppn = em[1] ? p2[35:0] : p1[35:0];
    egpa = (em == 2'b10) ? va[49:0] : (em[0] ? {p1[37:0], va[11:0]} : 50'd0);
    eaf  = (em == 2'b10) ? a2 : ((em == 2'b11) ? (a1 | a2) : a1);
    @(negedge clk);
    req_valid = 1'b1; req_virt = virt; req_guest_fld = g; req_host_fld = h; req_vaddr = va;
    @(negedge clk);
    // R7: scramble stage-0 inputs after acceptance
    req_valid = 1'b0; req_virt = ~virt; req_guest_fld = (g == 0) ? 4'h3 : 4'h0;
    req_host_fld = (h == 0) ? 4'h5 : 4'h0; req_vaddr = ~va;
    lk_s1_ppn = p1; lk_s2_ppn = p2; lk_s1_af = a1; lk_s2_af = a2;
    #1;
    check("R8 rsp_valid", 64'(rsp_valid), 64'd1);
    check(virt ? "R2/R7 mode" : "R1/R7 mode", 64'(rsp_mode), 64'(em));
    check("R3 ppn", 64'(rsp_ppn), 64'(eppn));
    check("R4 gpa", 64'(rsp_gpa), 64'(egpa));
    check("R5 af", 64'(rsp_af), 64'(eaf));
    check("R6 pf", 64'(rsp_pf), 64'(epf));
    check("R6 gpf", 64'(rsp_gpf), 64'(egpf));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errs++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9
    check("R9 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R9 req_ready", 64'(req_ready), 64'd1);

    for (int v = 0; v < 2; v++)
      for (int gi = 0; gi < 4; gi++)
        for (int hi = 0; hi < 4; hi++)
          for (int ai = 0; ai < 4; ai++)
            for (int fi = 0; fi < 4; fi++)
              one_req(v[0], fld_val(gi), fld_val(hi), va_val(ai),
                      44'hABC_DEF0_1234 + 44'(gi * 16 + hi * 4 + ai),
                      38'h2_5A5A_C3C3 + 38'(fi * 7 + v),
                      fi[0], fi[1]);

    // R8: back-pressure hold, then simultaneous consume and accept
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_virt = 1'b1; req_guest_fld = 4'h8; req_host_fld = 4'h0;
    req_vaddr = 64'h0001_0000_0000_0123;
    @(negedge clk);
    req_virt = 1'b0; req_guest_fld = 4'h0; req_vaddr = 64'h0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R8 held valid", 64'(rsp_valid), 64'd1);
      check("R8 ready low", 64'(req_ready), 64'd0);
      check("R8 held mode", 64'(rsp_mode), 64'd1);
      check("R8 held pf", 64'(rsp_pf), 64'd1);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    #1;
    check("R8 ready on consume", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R8 next valid", 64'(rsp_valid), 64'd1);
    check("R1 next mode", 64'(rsp_mode), 64'd0);
    check("R6 next pf", 64'(rsp_pf), 64'd0);
    @(negedge clk);
    #1;
    check("R8 drained", 64'(rsp_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule